// File: doc/BRIEF.md
# Selectable Self-Synchronizing Packet Scrambler

This block whitens 64-bit serializer packets so that long runs of identical converter codes (for example a converter stuck at full scale, giving all ones or all zeros) still give a stream with a fair mix of ones and zeros. It holds two independent lanes. The scramble lane takes plain packets and emits scrambled ones. The descramble lane takes scrambled packets and recovers the plain ones. Each lane handles one packet per clock. The lanes use an unrolled parallel form of a one-bit-per-step multiplicative recurrence. In that rule, each output bit equals the input bit XOR two delayed state bits. The scrambler feeds its own output into its state, and the descrambler feeds the received bit into its state. This lets the receiver lock by itself after a state length of covered bits, with no sync word.

Two control inputs choose the polynomial and the coverage. A small controller with two states, CTL_RUN and CTL_CLEAR, applies a new setting. In CTL_RUN it compares the control inputs with the applied setting. When they differ, it latches the new setting and moves to CTL_CLEAR. After exactly one cycle it returns from CTL_CLEAR to CTL_RUN, and while in CTL_CLEAR both lane states reload to all ones. Settings are meant to change only while no packets flow.

Top module: `pkt_scrambler`

## Requirements
- R1: While reset is held and on the first sampling after release, both output valids are low. Reset leaves both lane states at all ones, with polynomial code 0 and coverage code 0 applied.
- R2: An accepted input packet appears on the same lane's output one clock later with its valid high. With no input valid, the output valid is low in the next cycle.
- R3: Polynomial code 0 selects x^58+x^39+1: scrambled bit = plain bit XOR the state bits written 39 and 58 covered bits earlier, using a 58-bit state.
- R4: Polynomial code 1 selects x^7+x^6+1: scrambled bit = plain bit XOR the state bits written 6 and 7 covered bits earlier.
- R5: Coverage code 0 covers bits [63:0], code 1 covers bits [55:0] and code 2 covers bits [47:0]. Covered bits are processed from the highest index down, so the higher bit is the earlier serial bit.
- R6: Bits above the covered field leave the lane unchanged and do not advance the state.
- R7: The state carries from one packet to the next, so consecutive packets form one continuous stream. Cycles without an accepted packet leave the state unchanged.
- R8: The descrambler restores the plain packet exactly when it starts in step with the scrambler. From any starting state, it restores every covered bit that follows the first 58 (code 0) or 7 (code 1) received covered bits.
- R9: A packet presented in the cycle the settings change, or in the clear cycle that follows, is dropped and gives no output valid. The clear cycle reloads both states to all ones.
- R10: Coverage code 3 behaves exactly like coverage code 2.
- R11: The controller stays in CTL_CLEAR for exactly one cycle and then returns to CTL_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poly_sel | input | 1 | Polynomial code: 0 long, 1 short |
| cov_mode | input | 2 | Coverage code: 0 full, 1 header and data, 2 or 3 data only |
| scr_in_valid | input | 1 | Plain packet present |
| scr_in_data | input | 64 | Plain packet |
| scr_out_valid | output | 1 | Scrambled packet present |
| scr_out_data | output | 64 | Scrambled packet |
| dsc_in_valid | input | 1 | Received scrambled packet present |
| dsc_in_data | input | 64 | Received scrambled packet |
| dsc_out_valid | output | 1 | Recovered packet present |
| dsc_out_data | output | 64 | Recovered plain packet |

## Verification
The bench compares the lanes with a bit-serial model across both polynomials, every coverage code and constant all-zero and all-one data. A wrong tap, a reversed bit order or a wrong coverage boundary would therefore corrupt almost every packet. It starts the descrambler out of step with the scrambler and expects exact recovery only once a full state length of covered bits has arrived. A lane that fed its own output back instead of the received bit would never lock. It sends packets in the cycle the settings change and in the clear cycle, and it leaves idle gaps between packets. A design that let such packets through, skipped the reload, or advanced the state while idle would emit wrong packets afterwards.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        COV_FULL     = 2'd0,
        COV_HDR_DATA = 2'd1,
        COV_DATA     = 2'd2,
        COV_DATA_ALT = 2'd3
    } cov_mode_e;

    typedef enum logic {
        POLY_LONG  = 1'b0,
        POLY_SHORT = 1'b1
    } poly_e;

    typedef enum logic {
        CTL_RUN   = 1'b0,
        CTL_CLEAR = 1'b1
    } ctl_state_e;

    typedef struct packed {
        poly_e     poly;
        cov_mode_e cov;
    } scr_cfg_t;

endpackage

// File: rtl/scr_cfg_ctrl.sv
module scr_cfg_ctrl
    import scr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  scr_cfg_t cfg_in,
    output scr_cfg_t cfg_q,
    output logic     accept,
    output logic     clear
);

    ctl_state_e state_q, state_n;
    logic       cfg_diff;

    assign cfg_diff = (cfg_in != cfg_q);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CTL_RUN:   if (cfg_diff) state_n = CTL_CLEAR;
            CTL_CLEAR: state_n = CTL_RUN;
            default:   state_n = CTL_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_RUN;
            cfg_q   <= '{poly: POLY_LONG, cov: COV_FULL};
        end else begin
            state_q <= state_n;
            if (state_q == CTL_RUN && cfg_diff) cfg_q <= cfg_in;
        end
    end

    always_comb begin
        clear  = (state_q == CTL_CLEAR);
        accept = (state_q == CTL_RUN) && !cfg_diff;
    end

    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_CLEAR) |=> (state_q == CTL_RUN)); // R11

    AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_RUN && cfg_diff) |=> clear); // R9

endmodule

// File: rtl/scr_lane.sv
module scr_lane
    import scr_pkg::*;
#(
    parameter int PKT_W       = 64,
    parameter int DATA_W      = 48,
    parameter int HDR_W       = 8,
    parameter int ST_W        = 58,
    parameter int LONG_TAP_A  = 39,
    parameter int LONG_TAP_B  = 58,
    parameter int SHORT_TAP_A = 6,
    parameter int SHORT_TAP_B = 7,
    parameter bit DESCRAMBLE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scr_cfg_t          cfg,
    input  logic              accept,
    input  logic              clear,
    input  logic              in_valid,
    input  logic [PKT_W-1:0]  in_data,
    output logic              out_valid,
    output logic [PKT_W-1:0]  out_data
);

    localparam int HD_W  = DATA_W + HDR_W;
    localparam int CNT_W = $clog2(PKT_W + 1);
    localparam int IDX_W = $clog2(ST_W);

    logic [CNT_W-1:0] cov_w;
    logic [IDX_W-1:0] tap_a, tap_b;
    logic [ST_W-1:0]  st_q, st_n;
    logic [PKT_W-1:0] mix;
    logic             take;

    assign take = in_valid && accept;

    always_comb begin
        unique case (cfg.cov)
            COV_FULL:     cov_w = CNT_W'(PKT_W);
            COV_HDR_DATA: cov_w = CNT_W'(HD_W);
            default:      cov_w = CNT_W'(DATA_W);
        endcase
        if (cfg.poly == POLY_LONG) begin
            tap_a = IDX_W'(LONG_TAP_A - 1);
            tap_b = IDX_W'(LONG_TAP_B - 1);
        end else begin
            tap_a = IDX_W'(SHORT_TAP_A - 1);
            tap_b = IDX_W'(SHORT_TAP_B - 1);
        end
    end

    // Unrolled serial recurrence, highest covered bit first.
    always_comb begin
        logic [ST_W-1:0] walk;
        logic            fb;
        logic            fed;
        walk = st_q;
        mix  = in_data;
        fb   = 1'b0;
        fed  = 1'b0;
        for (int i = PKT_W - 1; i >= 0; i--) begin
            if (i < int'(cov_w)) begin
                fb     = walk[tap_a] ^ walk[tap_b];
                mix[i] = in_data[i] ^ fb;
                fed    = DESCRAMBLE ? in_data[i] : mix[i];
                walk   = {walk[ST_W-2:0], fed};
            end
        end
        st_n = walk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '1;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (clear) begin
            st_q      <= '1;
            out_valid <= 1'b0;
        end else begin
            out_valid <= take;
            if (take) begin
                st_q     <= st_n;
                out_data <= mix;
            end
        end
    end

    AST_CLEAR_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q == '1)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !take) |=> $stable(st_q)); // R7

    AST_PASS_UNCOVERED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cfg.cov != COV_FULL) |=>
        (out_data[PKT_W-1:HD_W] == $past(in_data[PKT_W-1:HD_W]))); // R6

    AST_NO_OUT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid); // R9

endmodule

// File: rtl/pkt_scrambler.sv
module pkt_scrambler
    import scr_pkg::*;
#(
    parameter int PKT_W  = 64,
    parameter int DATA_W = 48,
    parameter int HDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poly_sel,
    input  logic [1:0]        cov_mode,
    input  logic              scr_in_valid,
    input  logic [PKT_W-1:0]  scr_in_data,
    output logic              scr_out_valid,
    output logic [PKT_W-1:0]  scr_out_data,
    input  logic              dsc_in_valid,
    input  logic [PKT_W-1:0]  dsc_in_data,
    output logic              dsc_out_valid,
    output logic [PKT_W-1:0]  dsc_out_data
);

    localparam int LANES = 2;

    scr_cfg_t         cfg_in, cfg_q;
    logic             accept, clear;
    logic             l_in_v  [LANES];
    logic [PKT_W-1:0] l_in_d  [LANES];
    logic             l_out_v [LANES];
    logic [PKT_W-1:0] l_out_d [LANES];

    assign cfg_in.poly = poly_e'(poly_sel);
    assign cfg_in.cov  = cov_mode_e'(cov_mode);

    scr_cfg_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .accept (accept),
        .clear  (clear)
    );

    assign l_in_v[0] = scr_in_valid;
    assign l_in_d[0] = scr_in_data;
    assign l_in_v[1] = dsc_in_valid;
    assign l_in_d[1] = dsc_in_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        scr_lane #(
            .PKT_W      (PKT_W),
            .DATA_W     (DATA_W),
            .HDR_W      (HDR_W),
            .DESCRAMBLE (g == 1)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (cfg_q),
            .accept    (accept),
            .clear     (clear),
            .in_valid  (l_in_v[g]),
            .in_data   (l_in_d[g]),
            .out_valid (l_out_v[g]),
            .out_data  (l_out_d[g])
        );
    end

    assign scr_out_valid = l_out_v[0];
    assign scr_out_data  = l_out_d[0];
    assign dsc_out_valid = l_out_v[1];
    assign dsc_out_data  = l_out_d[1];

    AST_SCR_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        scr_out_valid |-> $past(scr_in_valid)); // R2

    AST_DSC_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_out_valid |-> $past(dsc_in_valid)); // R2

endmodule

// File: tb/tb_pkt_scrambler.sv
module tb_pkt_scrambler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poly_sel = 1'b0;
    logic [1:0]  cov_mode = 2'd0;
    logic        scr_in_valid = 1'b0;
    logic [63:0] scr_in_data = '0;
    logic        scr_out_valid;
    logic [63:0] scr_out_data;
    logic        dsc_in_valid = 1'b0;
    logic [63:0] dsc_in_data = '0;
    logic        dsc_out_valid;
    logic [63:0] dsc_out_data;

    int checks = 0;
    int errors = 0;
    logic [57:0] ms = '1;

    always #10 clk = ~clk;

    pkt_scrambler dut (
        .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .cov_mode(cov_mode),
        .scr_in_valid(scr_in_valid), .scr_in_data(scr_in_data),
        .scr_out_valid(scr_out_valid), .scr_out_data(scr_out_data),
        .dsc_in_valid(dsc_in_valid), .dsc_in_data(dsc_in_data),
        .dsc_out_valid(dsc_out_valid), .dsc_out_data(dsc_out_data)
    );

    typedef struct packed {
        logic       poly;
        logic [1:0] mode;
        logic [1:0] pat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd0}, '{1'b0, 2'd1, 2'd1}, '{1'b0, 2'd2, 2'd2},
        '{1'b1, 2'd0, 2'd1}, '{1'b1, 2'd1, 2'd0}, '{1'b1, 2'd2, 2'd3},
        '{1'b0, 2'd0, 2'd3}, '{1'b1, 2'd2, 2'd2}
    };

    function automatic int cov_bits(input logic [1:0] m);
        return (m == 2'd0) ? 64 : (m == 2'd1) ? 56 : 48;
    endfunction

    function automatic logic [63:0] pat_data(input logic [1:0] p, input int idx);
        case (p)
            2'd0:    return 64'd0;
            2'd1:    return '1;
            2'd2:    return 64'h0123_4567_89AB_CDEF ^ (64'(idx) * 64'h9E37_79B9_7F4A_7C15);
            default: return 64'hA5A5_5A5A_C3C3_3C3C ^ 64'(idx);
        endcase
    endfunction

    // Bit-serial reference: earliest serial bit is the highest covered index.
    task automatic model_pkt(input logic [63:0] d, output logic [63:0] q);
        logic fb;
        q = d;
        for (int k = cov_bits(cov_mode) - 1; k >= 0; k--) begin
            fb   = poly_sel ? (ms[5] ^ ms[6]) : (ms[38] ^ ms[57]);
            q[k] = d[k] ^ fb;
            ms   = {ms[56:0], q[k]};
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic p, input logic [1:0] m);
        if (p !== poly_sel || m !== cov_mode) begin
            poly_sel = p;
            cov_mode = m;
            ms = '1;
            repeat (2) @(negedge clk);
        end
    endtask

    // Drive one packet at a falling edge, check at the next falling edge.
    task automatic run_pkt(input logic [63:0] d, input bit to_dsc, input bit chk_dsc,
                           input string tag);
        logic [63:0] q;
        logic [63:0] hi;
        int          cw;
        cw = cov_bits(cov_mode);
        model_pkt(d, q);
        scr_in_valid = 1'b1;
        scr_in_data  = d;
        dsc_in_valid = to_dsc;
        dsc_in_data  = q;
        @(negedge clk);
        chk($sformatf("R2 %s valid", tag), 64'(scr_out_valid), 64'd1);
        chk(tag, scr_out_data, q);
        if (cw < 64) begin
            hi = ~((64'd1 << cw) - 64'd1);
            chk($sformatf("R6 %s", tag), scr_out_data & hi, d & hi);
        end
        if (chk_dsc) chk($sformatf("R8 %s", tag), dsc_out_data, d);
        scr_in_valid = 1'b0;
        dsc_in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 scr valid in reset", 64'(scr_out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scr valid after reset", 64'(scr_out_valid), 64'd0);
        chk("R1 dsc valid after reset", 64'(dsc_out_valid), 64'd0);

        // Table walk: both lanes in step, every polynomial and coverage code.
        for (int v = 0; v < NV; v++) begin
            apply_cfg(VECS[v].poly, VECS[v].mode);
            for (int n = 0; n < 6; n++)
                run_pkt(pat_data(VECS[v].pat, n), 1'b1, 1'b1,
                        $sformatf("%s R5 vec%0d pkt%0d", VECS[v].poly ? "R4" : "R3", v, n));
        end

        // R8 self-sync, long polynomial, data-only coverage.
        apply_cfg(1'b0, 2'd2);
        for (int n = 0; n < 3; n++) run_pkt(pat_data(2'd2, n), 1'b0, 1'b0, "R8 prime");
        for (int n = 0; n < 6; n++)
            run_pkt(pat_data(2'd1, n), 1'b1, (n >= 2), $sformatf("R8 lock58 pkt%0d", n));

        // R8 self-sync, short polynomial, full coverage.
        apply_cfg(1'b1, 2'd0);
        run_pkt(pat_data(2'd3, 9), 1'b0, 1'b0, "R8 prime");
        for (int n = 0; n < 4; n++)
            run_pkt(pat_data(2'd0, n), 1'b1, (n >= 1), $sformatf("R8 lock7 pkt%0d", n));

        // R7 idle gaps keep the state.
        apply_cfg(1'b0, 2'd1);
        run_pkt(pat_data(2'd2, 1), 1'b1, 1'b1, "R7 before gap");
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk("R2 idle no valid", 64'(scr_out_valid), 64'd0);
        end
        run_pkt(pat_data(2'd2, 2), 1'b1, 1'b1, "R7 after gap");

        // R9 and R11: packets during change and clear cycles are dropped.
        poly_sel     = 1'b1;
        scr_in_valid = 1'b1;
        scr_in_data  = 64'hFFFF_0000_FFFF_0000;
        dsc_in_valid = 1'b1;
        dsc_in_data  = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        chk("R9 change cycle dropped", 64'(scr_out_valid), 64'd0);
        chk("R9 change cycle dropped dsc", 64'(dsc_out_valid), 64'd0);
        @(negedge clk);
        chk("R11 clear cycle dropped", 64'(scr_out_valid), 64'd0);
        scr_in_valid = 1'b0;
        dsc_in_valid = 1'b0;
        ms = '1;
        run_pkt(pat_data(2'd1, 0), 1'b1, 1'b1, "R9 R11 after clear");
        run_pkt(pat_data(2'd1, 1), 1'b1, 1'b1, "R9 after clear 2");

        // R10 coverage code 3 equals data-only.
        apply_cfg(1'b0, 2'd3);
        for (int n = 0; n < 3; n++)
            run_pkt(pat_data(2'd1, n), 1'b1, 1'b1, $sformatf("R10 pkt%0d", n));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule